// File: doc/BRIEF.md
# Frame-counted byte FIFO with host command port

This block keeps one channel's worth of byte storage in two directions. A receive ring is filled from a byte stream that marks the last byte of each frame. A transmit ring is filled by software and drained onto an outgoing byte stream. Each ring is tracked twice. A pair of byte pointers (Z1 for writing, Z2 for reading) counts bytes. A pair of 5-bit frame counters (F1 for frames closed, F2 for frames released) counts whole frames. Software never sees the memories directly. Instead it issues single commands on a host port. Each command reads a counter or a pointer, moves one data byte, or steps a frame counter. An accepted command holds a busy flag for a fixed number of cycles, and a command that arrives while busy is high is dropped and counted.

In framed (HDLC) mode, every received frame ends in two checksum bytes and one status byte. The block drops any received frame shorter than four bytes. Each receive frame and each transmit frame is released or closed only by an explicit counter-step command. In transparent mode there are no frames: the byte pointers alone describe the data, and the frame commands do nothing.

Top module: `frame_byte_fifo`

## Requirements
- R1: An accepted host command (host_req high while host_busy is low) raises host_busy from the next cycle. It holds host_busy high for exactly BUSY_CYCLES cycles.
- R2: A host_req that arrives while host_busy is high has no effect on any FIFO state. It increments host_err_cnt, which saturates at 255.
- R3: Received bytes are stored in arrival order. Command 0 (pop) returns the byte at the receive Z2 and advances Z2. A pop on an empty receive ring returns 0x00 and leaves Z2 unchanged.
- R4: In HDLC mode, a received byte with rx_eof high of a frame of four or more bytes closes the frame and increments the receive F1. In this mode, a read of the receive Z1 returns the address of the last byte of the oldest pending frame. The frame length is therefore (Z1 − Z2 + 1) modulo the FIFO size. Stored end addresses reset to all ones.
- R5: In HDLC mode, a frame whose rx_eof byte makes it fewer than four bytes long is discarded. The receive F1 does not change, and its bytes are overwritten by the next frame.
- R6: Command 14 releases the oldest received frame in HDLC mode. It increments F2 and moves Z2 to the byte after that frame's end, even if the frame was only partly read. It has no effect when F1 equals F2 or in transparent mode.
- R7: Command 1 writes host_wdata at the transmit Z1. Command 15 closes the open transmit frame and increments the transmit F1. It is refused when 31 frames are already pending, or when no byte has been written since the last close.
- R8: In HDLC mode, tx_valid is high only while at least one closed frame is pending. tx_eof marks that frame's last byte. The transmit F2 increments when that byte is taken.
- R9: In transparent mode, rx_eof is ignored and a read of the receive Z1 returns the live write pointer. Transmit bytes flow out whenever any are stored, and tx_eof stays low. Command 15 has no effect.
- R10: rx_ready is low when the receive ring holds FIFO size − 1 bytes. In HDLC mode it is also low when 31 frames are pending. tx_space always equals FIFO size − 1 − (transmit bytes stored).
- R11: Pointer reads return the 13-bit pointer, zero-extended, as a high byte (bits 12:8) and a low byte (bits 7:0). Commands 6/7 read the receive Z1, 8/9 the receive Z2, 10/11 the transmit Z1 and 12/13 the transmit Z2. Commands 2, 3, 4 and 5 return the receive F1, receive F2, transmit F1 and transmit F2 in bits 4:0. Read data appears on host_rdata at acceptance and holds while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdlc_mode | input | 1 | 1 selects framed mode, 0 selects transparent mode |
| host_req | input | 1 | Host command request |
| host_cmd | input | 4 | Command code |
| host_wdata | input | 8 | Byte to write for command 1 |
| host_rdata | output | 8 | Result of the last accepted command |
| host_busy | output | 1 | Command in service |
| host_err_cnt | output | 8 | Requests rejected while busy |
| rx_valid | input | 1 | Receive byte present |
| rx_data | input | 8 | Receive byte |
| rx_eof | input | 1 | Byte is the last of its frame |
| rx_ready | output | 1 | Receive byte will be accepted |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_eof | output | 1 | Last byte of a transmit frame |
| tx_ready | input | 1 | Sink takes the transmit byte |
| tx_space | output | ADDR_W | Free transmit bytes |

## Verification
The bench builds a short receive frame between two good ones. A design that kept it would report the wrong frame count and the wrong end address for the following frame. It releases a frame that was only half read: a design that only stepped F2 would hand the leftover bytes to the next read. It fills the transmit side to 31 frames and attempts a 32nd close, and it also attempts a close with no new bytes. A design without these guards would wrap the frame counter or emit a frame with a bogus end. The bench also fills the receive ring to its last free byte, and it issues commands while busy is high, which a careless port would execute.

// File: rtl/frame_byte_fifo.sv
module frame_byte_fifo #(
  parameter int ADDR_W      = 9,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdlc_mode,
  input  logic              host_req,
  input  logic [3:0]        host_cmd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_busy,
  output logic [7:0]        host_err_cnt,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_eof,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_eof,
  input  logic              tx_ready,
  output logic [ADDR_W-1:0] tx_space
);
  localparam int SIZE = 1 << ADDR_W;
  localparam int BW   = $clog2(BUSY_CYCLES + 1);
  localparam logic [4:0] FMAX = 5'd31;
  typedef logic [ADDR_W-1:0] ptr_t;
  localparam ptr_t ONE = ptr_t'(1);

  logic [7:0] rx_mem [SIZE];
  logic [7:0] tx_mem [SIZE];
  ptr_t rx_end [32];
  ptr_t tx_end [32];
  ptr_t rx_z1, rx_z2, rx_fstart, tx_z1, tx_z2;
  logic [4:0] rx_f1, rx_f2, tx_f1, tx_f2;
  logic [2:0] rx_flen;
  logic tx_open;
  logic [BW-1:0] busy_cnt;
  logic [7:0] rd_next;

  ptr_t rx_used, tx_used, rx_z1_view;
  logic [4:0] rx_pend, tx_pend;
  logic accept, rx_write, rx_short, tx_take;
  logic pop_ok, push_ok, rxinc_ok, txinc_ok;

  assign rx_used    = rx_z1 - rx_z2;
  assign tx_used    = tx_z1 - tx_z2;
  assign rx_pend    = rx_f1 - rx_f2;
  assign tx_pend    = tx_f1 - tx_f2;
  assign rx_z1_view = hdlc_mode ? rx_end[rx_f2] : rx_z1;

  assign host_busy = busy_cnt != '0;
  assign accept    = host_req && !host_busy;
  assign rx_ready  = (rx_used != '1) && !(hdlc_mode && rx_pend == FMAX);
  assign rx_write  = rx_valid && rx_ready;
  assign rx_short  = hdlc_mode && rx_eof && rx_flen < 3'd3;
  assign tx_valid  = hdlc_mode ? tx_pend != '0 : tx_used != '0;
  assign tx_data   = tx_mem[tx_z2];
  assign tx_eof    = hdlc_mode && tx_valid && tx_z2 == tx_end[tx_f2];
  assign tx_take   = tx_valid && tx_ready;
  assign tx_space  = ~tx_used;

  assign pop_ok   = accept && host_cmd == 4'd0 && rx_used != '0;
  assign push_ok  = accept && host_cmd == 4'd1 && tx_used != '1;
  assign rxinc_ok = accept && host_cmd == 4'd14 && hdlc_mode && rx_pend != '0;
  assign txinc_ok = accept && host_cmd == 4'd15 && hdlc_mode && tx_open && tx_pend != FMAX;

  function automatic logic [7:0] z_hi(input ptr_t p);
    logic [12:0] w;
    w = 13'(p);
    return {3'b000, w[12:8]};
  endfunction

  function automatic logic [7:0] z_lo(input ptr_t p);
    logic [12:0] w;
    w = 13'(p);
    return w[7:0];
  endfunction

  always_comb begin
    rd_next = '0;
    case (host_cmd)
      4'd0:  if (rx_used != '0) rd_next = rx_mem[rx_z2];
      4'd2:  rd_next = {3'b000, rx_f1};
      4'd3:  rd_next = {3'b000, rx_f2};
      4'd4:  rd_next = {3'b000, tx_f1};
      4'd5:  rd_next = {3'b000, tx_f2};
      4'd6:  rd_next = z_hi(rx_z1_view);
      4'd7:  rd_next = z_lo(rx_z1_view);
      4'd8:  rd_next = z_hi(rx_z2);
      4'd9:  rd_next = z_lo(rx_z2);
      4'd10: rd_next = z_hi(tx_z1);
      4'd11: rd_next = z_lo(tx_z1);
      4'd12: rd_next = z_hi(tx_z2);
      4'd13: rd_next = z_lo(tx_z2);
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rx_write) rx_mem[rx_z1] <= rx_data;
    if (push_ok)  tx_mem[tx_z1] <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_z1 <= '0; rx_fstart <= '0; rx_f1 <= '0; rx_flen <= '0;
      for (int i = 0; i < 32; i++) rx_end[i] <= '1;
    end else if (rx_write) begin
      if (hdlc_mode && rx_eof) begin
        rx_flen <= '0;
        if (rx_short) rx_z1 <= rx_fstart;
        else begin
          rx_z1         <= rx_z1 + ONE;
          rx_fstart     <= rx_z1 + ONE;
          rx_end[rx_f1] <= rx_z1;
          rx_f1         <= rx_f1 + 5'd1;
        end
      end else begin
        rx_z1 <= rx_z1 + ONE;
        if (hdlc_mode && rx_flen != 3'd4) rx_flen <= rx_flen + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0; host_err_cnt <= '0; host_rdata <= '0;
      rx_z2 <= '0; rx_f2 <= '0; tx_z1 <= '0; tx_f1 <= '0; tx_open <= 1'b0;
      for (int i = 0; i < 32; i++) tx_end[i] <= '1;
    end else begin
      if (accept) begin
        busy_cnt   <= BW'(BUSY_CYCLES);
        host_rdata <= rd_next;
      end else if (host_busy) begin
        busy_cnt <= busy_cnt - 1'b1;
        if (host_req && host_err_cnt != 8'hFF) host_err_cnt <= host_err_cnt + 8'd1;
      end
      if (pop_ok) rx_z2 <= rx_z2 + ONE;
      if (rxinc_ok) begin
        rx_z2 <= rx_end[rx_f2] + ONE;
        rx_f2 <= rx_f2 + 5'd1;
      end
      if (push_ok) begin
        tx_z1   <= tx_z1 + ONE;
        tx_open <= 1'b1;
      end
      if (txinc_ok) begin
        tx_end[tx_f1] <= tx_z1 - ONE;
        tx_f1         <= tx_f1 + 5'd1;
        tx_open       <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_z2 <= '0; tx_f2 <= '0;
    end else if (tx_take) begin
      tx_z2 <= tx_z2 + ONE;
      if (tx_eof) tx_f2 <= tx_f2 + 5'd1;
    end
  end

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> host_busy);

  // R2
  err_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_busy && host_err_cnt != 8'hFF) |=> host_err_cnt == $past(host_err_cnt) + 8'd1);

  // R5
  short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_write && rx_short) |=> (rx_z1 == $past(rx_fstart)) && $stable(rx_f1));

  // R6
  release_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && host_cmd == 4'd14 && hdlc_mode && rx_f1 != rx_f2) |=> rx_f2 == $past(rx_f2) + 5'd1);

  // R7
  tx_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && host_cmd == 4'd15 && tx_pend == FMAX) |=> $stable(tx_f1));

  // R8
  tx_frame_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_eof) |=> tx_f2 == $past(tx_f2) + 5'd1);
endmodule

// File: tb/frame_byte_fifo_tb.sv
`timescale 1ns/1ps
module frame_byte_fifo_tb_top;
  localparam int AW = 9;
  localparam int SIZE = 1 << AW;
  localparam int BUSY = 4;

  logic clk = 1'b0, rst_n = 1'b0, hdlc_mode = 1'b1;
  logic host_req = 1'b0;
  logic [3:0] host_cmd = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata, host_err_cnt;
  logic host_busy;
  logic rx_valid = 1'b0, rx_eof = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic tx_valid, tx_eof, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic [AW-1:0] tx_space;

  always #2.5 clk = ~clk;

  frame_byte_fifo #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .hdlc_mode(hdlc_mode),
    .host_req(host_req), .host_cmd(host_cmd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_busy(host_busy), .host_err_cnt(host_err_cnt),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_eof(tx_eof), .tx_ready(tx_ready),
    .tx_space(tx_space));

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_busy, m_err, m_rd;
  int mrz1, mrz2, mrfs, mrflen, mrf1, mrf2, mtz1, mtz2, mtf1, mtf2;
  bit mtopen;
  int mrx [SIZE];
  int mtx [SIZE];
  int mrend [32];
  int mtend [32];

  function automatic int md(input int v);
    return ((v % SIZE) + SIZE) % SIZE;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_rd = 0;
      mrz1 = 0; mrz2 = 0; mrfs = 0; mrflen = 0; mrf1 = 0; mrf2 = 0;
      mtz1 = 0; mtz2 = 0; mtf1 = 0; mtf2 = 0; mtopen = 0;
      for (int i = 0; i < 32; i++) begin mrend[i] = SIZE - 1; mtend[i] = SIZE - 1; end
    end else begin
      int rused, tused, rpend, tpend, zv;
      bit rrdy, tv, te;
      rused = md(mrz1 - mrz2); tused = md(mtz1 - mtz2);
      rpend = (mrf1 - mrf2) & 31; tpend = (mtf1 - mtf2) & 31;
      rrdy = (rused != SIZE - 1) && !(hdlc_mode && rpend == 31);
      tv = hdlc_mode ? tpend != 0 : tused != 0;
      te = hdlc_mode && tv && (mtz2 == mtend[mtf2]);
      if (host_req && m_busy > 0) begin
        if (m_err < 255) m_err++;
        m_busy--;
      end else if (host_req) begin
        m_busy = BUSY;
        m_rd = 0;
        zv = hdlc_mode ? mrend[mrf2] : mrz1;
        case (host_cmd)
          4'd0: if (rused != 0) begin m_rd = mrx[mrz2]; mrz2 = md(mrz2 + 1); end
          4'd1: if (tused != SIZE - 1) begin mtx[mtz1] = host_wdata; mtz1 = md(mtz1 + 1); mtopen = 1; end
          4'd2: m_rd = mrf1;
          4'd3: m_rd = mrf2;
          4'd4: m_rd = mtf1;
          4'd5: m_rd = mtf2;
          4'd6: m_rd = zv / 256;
          4'd7: m_rd = zv % 256;
          4'd8: m_rd = mrz2 / 256;
          4'd9: m_rd = mrz2 % 256;
          4'd10: m_rd = mtz1 / 256;
          4'd11: m_rd = mtz1 % 256;
          4'd12: m_rd = mtz2 / 256;
          4'd13: m_rd = mtz2 % 256;
          4'd14: if (hdlc_mode && rpend != 0) begin mrz2 = md(mrend[mrf2] + 1); mrf2 = (mrf2 + 1) & 31; end
          default: if (hdlc_mode && mtopen && tpend != 31) begin
            mtend[mtf1] = md(mtz1 - 1); mtf1 = (mtf1 + 1) & 31; mtopen = 0;
          end
        endcase
      end else if (m_busy > 0) m_busy--;
      if (rx_valid && rrdy) begin
        mrx[mrz1] = rx_data;
        if (hdlc_mode && rx_eof) begin
          if (mrflen + 1 < 4) mrz1 = mrfs;
          else begin
            mrend[mrf1] = mrz1; mrf1 = (mrf1 + 1) & 31;
            mrz1 = md(mrz1 + 1); mrfs = mrz1;
          end
          mrflen = 0;
        end else begin
          mrz1 = md(mrz1 + 1);
          if (hdlc_mode) mrflen++;
        end
      end
      if (tv && tx_ready) begin
        if (te) mtf2 = (mtf2 + 1) & 31;
        mtz2 = md(mtz2 + 1);
      end
    end
  end

  int eof_seen = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int tused, tpend;
      bit tv, te;
      tused = md(mtz1 - mtz2); tpend = (mtf1 - mtf2) & 31;
      tv = hdlc_mode ? tpend != 0 : tused != 0;
      te = hdlc_mode && tv && (mtz2 == mtend[mtf2]);
      chk(host_busy == (m_busy > 0), "R1 busy", host_busy, m_busy > 0);
      chk(host_err_cnt == 8'(m_err), "R2 err_cnt", host_err_cnt, m_err);
      chk(host_rdata == 8'(m_rd), "R11 rdata", host_rdata, m_rd);
      chk(rx_ready == ((md(mrz1 - mrz2) != SIZE - 1) && !(hdlc_mode && ((mrf1 - mrf2) & 31) == 31)),
          "R10 rx_ready", rx_ready, !rx_ready);
      chk(int'(tx_space) == SIZE - 1 - tused, "R10 tx_space", tx_space, SIZE - 1 - tused);
      chk(tx_valid == tv, hdlc_mode ? "R8 tx_valid" : "R9 tx_valid", tx_valid, tv);
      if (tv) begin
        chk(tx_data == 8'(mtx[mtz2]), "R8 tx_data", tx_data, mtx[mtz2]);
        chk(tx_eof == te, hdlc_mode ? "R8 tx_eof" : "R9 tx_eof", tx_eof, te);
      end
      if (tx_valid && tx_ready && tx_eof) eof_seen++;
    end
  end

  task automatic op(input logic [3:0] c, input logic [7:0] w, output int r);
    host_cmd = c; host_wdata = w; host_req = 1'b1;
    @(posedge clk); #1;
    host_req = 1'b0;
    repeat (BUSY) @(posedge clk);
    #1;
    r = host_rdata;
  endtask

  task automatic rd_ptr(input logic [3:0] hi_cmd, output int v);
    int h, l;
    op(hi_cmd, 8'h00, h);
    op(hi_cmd + 4'd1, 8'h00, l);
    v = h * 256 + l;
  endtask

  task automatic rx_frame(input int n, input int base, input bit eof_last);
    for (int i = 0; i < n; i++) begin
      while (!rx_ready) begin @(posedge clk); #1; end
      rx_valid = 1'b1; rx_data = 8'(base + i); rx_eof = eof_last && (i == n - 1);
      @(posedge clk); #1;
    end
    rx_valid = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic do_reset(input bit mode);
    rst_n = 1'b0; hdlc_mode = mode;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int v, r, hb;
    do_reset(1'b1);
    // reset state
    chk(host_busy == 1'b0, "R1 reset busy", host_busy, 0);
    chk(tx_valid == 1'b0, "R8 reset tx_valid", tx_valid, 0);
    rd_ptr(4'd6, v);
    chk(v == SIZE - 1, "R4 R11 reset end pointer", v, SIZE - 1);

    // busy length
    host_cmd = 4'd2; host_req = 1'b1;
    @(posedge clk); #1 host_req = 1'b0;
    hb = 0;
    for (int i = 0; i < BUSY + 3; i++) begin
      @(negedge clk); if (host_busy) hb++;
    end
    chk(hb == BUSY, "R1 busy cycles", hb, BUSY);

    // frame A: 6 bytes
    rx_frame(6, 8'hA0, 1);
    op(4'd2, 0, r); chk(r == 1, "R4 rx F1 after frame", r, 1);
    rd_ptr(4'd6, v); chk(v == 5, "R4 rx Z1 frame end", v, 5);
    rd_ptr(4'd8, r); chk(md(v - r + 1) == 6, "R4 frame length", md(v - r + 1), 6);
    // short frame then frame C
    rx_frame(3, 8'hB0, 1);
    op(4'd2, 0, r); chk(r == 1, "R5 short frame not counted", r, 1);
    rx_frame(4, 8'hC0, 1);
    op(4'd2, 0, r); chk(r == 2, "R5 next frame counted", r, 2);
    // partial read of A then release
    op(4'd0, 0, r); chk(r == 8'hA0, "R3 pop first", r, 8'hA0);
    op(4'd0, 0, r); chk(r == 8'hA1, "R3 pop second", r, 8'hA1);
    op(4'd14, 0, r);
    op(4'd3, 0, r); chk(r == 1, "R6 F2 stepped", r, 1);
    rd_ptr(4'd8, v); chk(v == 6, "R6 Z2 past frame", v, 6);
    rd_ptr(4'd6, v); chk(v == 9, "R5 R4 next frame end over short frame", v, 9);
    for (int i = 0; i < 4; i++) begin
      op(4'd0, 0, r); chk(r == 8'hC0 + i, "R3 pop frame C", r, 8'hC0 + i);
    end
    op(4'd14, 0, r);
    op(4'd14, 0, r);
    op(4'd3, 0, r); chk(r == 2, "R6 release with none pending ignored", r, 2);
    op(4'd0, 0, r); chk(r == 0, "R3 pop empty data", r, 0);
    rd_ptr(4'd8, v); chk(v == 10, "R3 pop empty keeps Z2", v, 10);

    // request while busy is dropped
    host_cmd = 4'd2; host_req = 1'b1;
    @(posedge clk); #1 host_cmd = 4'd1; host_wdata = 8'hAA;
    @(posedge clk); #1 host_req = 1'b0;
    repeat (BUSY) @(posedge clk);
    #1;
    chk(host_err_cnt == 8'd1, "R2 error counted", host_err_cnt, 1);
    rd_ptr(4'd10, v); chk(v == 0, "R2 dropped push had no effect", v, 0);

    // transmit frames, sink stalled
    op(4'd1, 8'h10, r); op(4'd1, 8'h11, r); op(4'd1, 8'h12, r);
    chk(tx_valid == 1'b0, "R8 open frame not sent", tx_valid, 0);
    op(4'd15, 0, r);
    op(4'd4, 0, r); chk(r == 1, "R7 close frame", r, 1);
    op(4'd15, 0, r);
    op(4'd4, 0, r); chk(r == 1, "R7 empty close refused", r, 1);
    for (int k = 1; k <= 30; k++) begin
      op(4'd1, 8'(8'h40 + k), r); op(4'd15, 0, r);
    end
    op(4'd4, 0, r); chk(r == 31, "R7 31 frames pending", r, 31);
    op(4'd1, 8'h77, r); op(4'd15, 0, r);
    op(4'd4, 0, r); chk(r == 31, "R7 32nd close refused", r, 31);
    chk(int'(tx_space) == SIZE - 1 - 34, "R10 tx space", tx_space, SIZE - 1 - 34);
    eof_seen = 0;
    tx_ready = 1'b1;
    repeat (60) @(posedge clk);
    #1;
    chk(eof_seen == 31, "R8 frame ends seen", eof_seen, 31);
    chk(tx_valid == 1'b0, "R8 unclosed byte held", tx_valid, 1);
    op(4'd5, 0, r); chk(r == 31, "R8 tx F2 after drain", r, 31);
    tx_ready = 1'b0;

    // receive frame-slot limit
    for (int k = 0; k < 31; k++) rx_frame(4, k * 4, 1);
    @(negedge clk);
    chk(rx_ready == 1'b0, "R10 rx slots full", rx_ready, 0);

    // transparent mode
    do_reset(1'b0);
    rx_valid = 1'b1; rx_data = 8'h51; @(posedge clk); #1;
    rx_data = 8'h52; @(posedge clk); #1;
    rx_data = 8'h53; rx_eof = 1'b1; @(posedge clk); #1;
    rx_eof = 1'b0; rx_data = 8'h54; @(posedge clk); #1;
    rx_data = 8'h55; @(posedge clk); #1;
    rx_valid = 1'b0;
    rd_ptr(4'd6, v); chk(v == 5, "R9 live write pointer", v, 5);
    op(4'd2, 0, r); chk(r == 0, "R9 eof ignored", r, 0);
    for (int i = 0; i < 5; i++) begin
      op(4'd0, 0, r); chk(r == 8'h51 + i, "R9 R3 transparent pop", r, 8'h51 + i);
    end
    eof_seen = 0;
    tx_ready = 1'b1;
    op(4'd1, 8'h61, r); op(4'd1, 8'h62, r); op(4'd15, 0, r);
    repeat (4) @(posedge clk);
    #1;
    chk(eof_seen == 0, "R9 no tx eof", eof_seen, 0);
    op(4'd4, 0, r); chk(r == 0, "R9 close ignored", r, 0);
    rd_ptr(4'd12, v); chk(v == 2, "R9 tx drained", v, 2);
    rx_frame(SIZE - 1, 0, 0);
    @(negedge clk);
    chk(rx_ready == 1'b0, "R10 rx ring full", rx_ready, 0);
    rd_ptr(4'd6, v); chk(v == 4, "R11 wrapped pointer", v, 4);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule